// File: doc/BRIEF.md
# DMA Channel Transfer-End Controller

This block holds the counting and stop logic of a single DMA channel. Register-style inputs load a transfer count, a segment count and a segment size, and select one of three transfer modes. The data mover sends a one-cycle completion strobe for each unit it moves. The block counts these strobes and decides when the channel must stop. It keeps the channel enable and activity bits, two sticky event flags and a combined interrupt request.

In normal mode the channel runs until the transfer count reaches zero. In repeat and block modes it counts units inside a segment. When a segment completes, the size counter reloads from the saved size and the segment count steps down. The channel ends when the last segment finishes.

An optional segment-boundary stop pauses the channel after each segment except the last and raises its own flag. Setting the enable again continues from the point where the channel paused. Address generation, bus access and the interrupt controller sit outside the block.

Top module: `dma_xfer_end_ctrl`

## Requirements
- R1: After reset, enable, activity, both flags and the interrupt request are 0, and all three counters read 0.
- R2: The mode field selects the mode: 2'b00 is normal, 2'b01 is repeat and 2'b10 is block. 2'b11 is reserved: a set-enable request is ignored and the enable stays 0.
- R3: A set-enable request is ignored while the count needed by the loaded mode is zero. That count is the transfer count in normal mode, and the segment count or segment size in repeat and block modes.
- R4: In normal mode each accepted strobe decrements the transfer count. The strobe that takes it from 1 to 0 clears enable and activity and sets the end flag, all at the same clock edge.
- R5: In repeat and block modes each accepted strobe decrements the size counter. The strobe that finds it at 1 reloads it from the saved size and decrements the segment count. When the segment count goes from 1 to 0, the channel ends exactly as in R4.
- R6: In repeat and block modes with the segment stop enabled, completing any segment but the last clears enable and sets the segment flag. Completing the last segment sets only the end flag.
- R7: A set-enable request after a segment stop restarts counting from the preserved counter values.
- R8: Completion strobes received while enable is 0 leave all counters unchanged.
- R9: Activity rises with the first accepted strobe after enable is set. It is never 1 while enable is 0.
- R10: Both flags are sticky until cleared. In flag_clr_i, bit 0 clears the end flag and bit 1 clears the segment flag. A set event in the same cycle as a clear wins.
- R11: irq_o is the combinational OR of (end flag AND ie_end_i) and (segment flag AND ie_seg_irq_i).
- R12: A clear-enable request stops the channel without setting any flag and keeps the counter values.
- R13: A configuration load received while enable is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load mode, counts and size |
| cfg_mode_i | input | 2 | Transfer mode |
| cfg_main_i | input | CNT_W | Transfer count, normal mode |
| cfg_seg_i | input | SEG_W | Segment count |
| cfg_size_i | input | SIZE_W | Units per segment |
| ie_end_i | input | 1 | End interrupt enable |
| ie_seg_stop_i | input | 1 | Stop at segment boundaries |
| ie_seg_irq_i | input | 1 | Segment interrupt enable |
| en_set_i | input | 1 | Request enable = 1 |
| en_clr_i | input | 1 | Request enable = 0 |
| flag_clr_i | input | 2 | Flag clear (bit0 end, bit1 segment) |
| unit_done_i | input | 1 | One unit moved |
| en_o | output | 1 | Channel enable |
| act_o | output | 1 | Transfer in progress |
| end_flag_o | output | 1 | Transfer ended |
| seg_flag_o | output | 1 | Segment stop occurred |
| irq_o | output | 1 | Interrupt request |
| main_cnt_o | output | CNT_W | Transfer count |
| seg_cnt_o | output | SEG_W | Segment count |
| size_cnt_o | output | SIZE_W | Units left in segment |

## Verification
The bench builds the block with CNT_W=6, SEG_W=3 and SIZE_W=3. With these widths a full-scale normal transfer of 63 units and a 7 x 7 segmented transfer both run in a few hundred cycles, so the counter end values are exercised, not only small counts. A segment size of 1 makes every strobe close a segment. A single-segment run with the stop enabled shows that the end takes priority over the segment stop.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  typedef enum logic [1:0] {
    XM_NORMAL = 2'b00,
    XM_REPEAT = 2'b01,
    XM_BLOCK  = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  function automatic logic seg_mode(input xfer_mode_e m);
    return (m == XM_REPEAT) || (m == XM_BLOCK);
  endfunction
endpackage

// File: rtl/dxe_counters.sv
module dxe_counters
  import dxe_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEG_W  = 10,
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  xfer_mode_e        mode_i,
  input  logic [CNT_W-1:0]  main_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              step_i,
  output xfer_mode_e        mode_o,
  output logic [CNT_W-1:0]  main_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              final_o,
  output logic              seg_end_o,
  output logic              can_start_o
);
  localparam logic [CNT_W-1:0]  M_ONE = 1;
  localparam logic [SEG_W-1:0]  G_ONE = 1;
  localparam logic [SIZE_W-1:0] S_ONE = 1;

  xfer_mode_e        mode_q;
  logic [CNT_W-1:0]  main_q;
  logic [SEG_W-1:0]  seg_q;
  logic [SIZE_W-1:0] size_q, size_rel_q;

  function automatic logic [CNT_W-1:0] next_main(input logic [CNT_W-1:0] v);
    return v - M_ONE;
  endfunction

  function automatic logic [SEG_W-1:0] next_seg(input logic [SEG_W-1:0] v,
                                                input logic wrap);
    return wrap ? v - G_ONE : v;
  endfunction

  function automatic logic [SIZE_W-1:0] next_size(input logic [SIZE_W-1:0] v,
                                                  input logic [SIZE_W-1:0] rel);
    return (v == S_ONE) ? rel : v - S_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= XM_NORMAL;
      main_q     <= '0;
      seg_q      <= '0;
      size_q     <= '0;
      size_rel_q <= '0;
    end else if (load_i) begin
      mode_q     <= mode_i;
      main_q     <= main_i;
      seg_q      <= seg_i;
      size_q     <= size_i;
      size_rel_q <= size_i;
    end else if (step_i) begin
      if (mode_q == XM_NORMAL) begin
        main_q <= next_main(main_q);
      end else if (seg_mode(mode_q)) begin
        seg_q  <= next_seg(seg_q, size_q == S_ONE);
        size_q <= next_size(size_q, size_rel_q);
      end
    end
  end

  always_comb begin
    seg_end_o = seg_mode(mode_q) && (size_q == S_ONE);
    final_o   = ((mode_q == XM_NORMAL) && (main_q == M_ONE)) ||
                (seg_end_o && (seg_q == G_ONE));
    case (mode_q)
      XM_NORMAL: can_start_o = (main_q != '0);
      XM_REPEAT,
      XM_BLOCK:  can_start_o = (seg_q != '0) && (size_q != '0);
      default:   can_start_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;
  assign main_o = main_q;
  assign seg_o  = seg_q;
  assign size_o = size_q;
endmodule

// File: rtl/dxe_chan_ctl.sv
module dxe_chan_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic can_start_i,
  input  logic unit_done_i,
  input  logic final_i,
  input  logic seg_end_i,
  input  logic seg_stop_en_i,
  output logic en_o,
  output logic act_o,
  output logic unit_ok_o,
  output logic end_evt_o,
  output logic seg_evt_o
);
  logic en_q, act_q, en_d;

  assign unit_ok_o = en_q && unit_done_i;
  assign end_evt_o = unit_ok_o && final_i;
  assign seg_evt_o = unit_ok_o && seg_end_i && !final_i && seg_stop_en_i;

  always_comb begin
    if (en_q) en_d = !(end_evt_o || seg_evt_o || en_clr_i);
    else      en_d = en_set_i && can_start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      act_q <= en_d && (act_q || unit_ok_o);
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
endmodule

// File: rtl/dxe_flags.sv
module dxe_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       end_evt_i,
  input  logic       seg_evt_i,
  input  logic [1:0] clr_i,
  input  logic       ie_end_i,
  input  logic       ie_seg_i,
  output logic       end_flag_o,
  output logic       seg_flag_o,
  output logic       irq_o
);
  logic end_q, seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      seg_q <= 1'b0;
    end else begin
      end_q <= end_evt_i || (end_q && !clr_i[0]);
      seg_q <= seg_evt_i || (seg_q && !clr_i[1]);
    end
  end

  assign end_flag_o = end_q;
  assign seg_flag_o = seg_q;
  assign irq_o      = (end_q && ie_end_i) || (seg_q && ie_seg_i);
endmodule

// File: rtl/dma_xfer_end_ctrl.sv
module dma_xfer_end_ctrl
  import dxe_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEG_W  = 10,
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic [CNT_W-1:0]  cfg_main_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic [SIZE_W-1:0] cfg_size_i,
  input  logic              ie_end_i,
  input  logic              ie_seg_stop_i,
  input  logic              ie_seg_irq_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic [1:0]        flag_clr_i,
  input  logic              unit_done_i,
  output logic              en_o,
  output logic              act_o,
  output logic              end_flag_o,
  output logic              seg_flag_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  main_cnt_o,
  output logic [SEG_W-1:0]  seg_cnt_o,
  output logic [SIZE_W-1:0] size_cnt_o
);
  xfer_mode_e mode_q;
  logic load_ok, unit_ok, end_evt, seg_evt;
  logic final_w, seg_end_w, can_start_w;

  assign load_ok = cfg_load_i && !en_o;

  dxe_counters #(.CNT_W(CNT_W), .SEG_W(SEG_W), .SIZE_W(SIZE_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_ok),
    .mode_i(xfer_mode_e'(cfg_mode_i)), .main_i(cfg_main_i),
    .seg_i(cfg_seg_i), .size_i(cfg_size_i), .step_i(unit_ok),
    .mode_o(mode_q), .main_o(main_cnt_o), .seg_o(seg_cnt_o),
    .size_o(size_cnt_o), .final_o(final_w), .seg_end_o(seg_end_w),
    .can_start_o(can_start_w)
  );

  dxe_chan_ctl ctl_i (
    .clk(clk), .rst_n(rst_n), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .can_start_i(can_start_w), .unit_done_i(unit_done_i),
    .final_i(final_w), .seg_end_i(seg_end_w),
    .seg_stop_en_i(ie_seg_stop_i), .en_o(en_o), .act_o(act_o),
    .unit_ok_o(unit_ok), .end_evt_o(end_evt), .seg_evt_o(seg_evt)
  );

  dxe_flags flg_i (
    .clk(clk), .rst_n(rst_n), .end_evt_i(end_evt), .seg_evt_i(seg_evt),
    .clr_i(flag_clr_i), .ie_end_i(ie_end_i), .ie_seg_i(ie_seg_irq_i),
    .end_flag_o(end_flag_o), .seg_flag_o(seg_flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/dxe_chk.sv
module dxe_chk
  import dxe_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEG_W  = 10,
  parameter int SIZE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load_i,
  input logic              ie_end_i,
  input logic              ie_seg_irq_i,
  input logic [1:0]        flag_clr_i,
  input logic              en_o,
  input logic              act_o,
  input logic              end_flag_o,
  input logic              seg_flag_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  main_cnt_o,
  input logic [SEG_W-1:0]  seg_cnt_o,
  input logic [SIZE_W-1:0] size_cnt_o,
  input xfer_mode_e        mode_q,
  input logic              end_evt,
  input logic              seg_evt
);
  assert_end_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!en_o && !act_o && end_flag_o));

  assert_seg_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_evt |=> (!en_o && seg_flag_o));

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_evt && seg_evt));

  assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !cfg_load_i) |=>
      ($stable(main_cnt_o) && $stable(seg_cnt_o) && $stable(size_cnt_o)));

  assert_reserved_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XM_RSVD) |-> !en_o);

  assert_act_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> en_o);

  assert_irq_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((end_flag_o && ie_end_i) || (seg_flag_o && ie_seg_irq_i)));

  assert_run_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && mode_q == XM_NORMAL) |-> (main_cnt_o != '0));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag_o && !flag_clr_i[0]) |=> end_flag_o);
endmodule

bind dma_xfer_end_ctrl dxe_chk #(.CNT_W(CNT_W), .SEG_W(SEG_W), .SIZE_W(SIZE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load_i), .ie_end_i(ie_end_i),
  .ie_seg_irq_i(ie_seg_irq_i), .flag_clr_i(flag_clr_i), .en_o(en_o),
  .act_o(act_o), .end_flag_o(end_flag_o), .seg_flag_o(seg_flag_o),
  .irq_o(irq_o), .main_cnt_o(main_cnt_o), .seg_cnt_o(seg_cnt_o),
  .size_cnt_o(size_cnt_o), .mode_q(mode_q), .end_evt(end_evt),
  .seg_evt(seg_evt)
);

// File: tb/dma_xfer_end_ctrl_tb_top.sv
`timescale 1ns/100ps
module dma_xfer_end_ctrl_tb_top;
  localparam int CW = 6;
  localparam int GW = 3;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, ie_end = 0, ie_seg_stop = 0, ie_seg_irq = 0;
  logic en_set = 0, en_clr = 0, unit_done = 0;
  logic [1:0] cfg_mode = 0, flag_clr = 0;
  logic [CW-1:0] cfg_main = 0;
  logic [GW-1:0] cfg_seg = 0;
  logic [SW-1:0] cfg_size = 0;
  logic en, act, end_flag, seg_flag, irq;
  logic [CW-1:0] main_cnt;
  logic [GW-1:0] seg_cnt;
  logic [SW-1:0] size_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_xfer_end_ctrl #(.CNT_W(CW), .SEG_W(GW), .SIZE_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_mode_i(cfg_mode),
    .cfg_main_i(cfg_main), .cfg_seg_i(cfg_seg), .cfg_size_i(cfg_size),
    .ie_end_i(ie_end), .ie_seg_stop_i(ie_seg_stop), .ie_seg_irq_i(ie_seg_irq),
    .en_set_i(en_set), .en_clr_i(en_clr), .flag_clr_i(flag_clr),
    .unit_done_i(unit_done), .en_o(en), .act_o(act), .end_flag_o(end_flag),
    .seg_flag_o(seg_flag), .irq_o(irq), .main_cnt_o(main_cnt),
    .seg_cnt_o(seg_cnt), .size_cnt_o(size_cnt)
  );

  // {mode[2], main[6], seg[3], size[3], stop_en[1], units[7], ends[1]}
  localparam logic [22:0] VEC [0:7] = '{
    {2'b00, 6'd5,  3'd0, 3'd0, 1'b0, 7'd5,  1'b1},
    {2'b01, 6'd0,  3'd3, 3'd2, 1'b0, 7'd6,  1'b1},
    {2'b10, 6'd0,  3'd2, 3'd3, 1'b0, 7'd6,  1'b1},
    {2'b01, 6'd0,  3'd3, 3'd2, 1'b1, 7'd2,  1'b0},
    {2'b10, 6'd0,  3'd1, 3'd4, 1'b1, 7'd4,  1'b1},
    {2'b00, 6'd63, 3'd0, 3'd0, 1'b0, 7'd63, 1'b1},
    {2'b01, 6'd0,  3'd7, 3'd7, 1'b0, 7'd49, 1'b1},
    {2'b10, 6'd0,  3'd3, 3'd1, 1'b1, 7'd1,  1'b0}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic load(input logic [1:0] m, input int mc, input int sc, input int zc);
    @(negedge clk);
    cfg_mode = m; cfg_main = CW'(mc); cfg_seg = GW'(sc); cfg_size = SW'(zc);
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic set_en();
    @(negedge clk); en_set = 1;
    @(negedge clk); en_set = 0;
  endtask

  task automatic unit_pulse();
    @(negedge clk); unit_done = 1;
    @(negedge clk); unit_done = 0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 en", int'(en), 0);
    check("R1 act", int'(act), 0);
    check("R1 flags", int'({end_flag, seg_flag, irq}), 0);
    check("R1 counts", int'(main_cnt) + int'(seg_cnt) + int'(size_cnt), 0);
    rst_n = 1;

    // Table walk: R4, R5, R6 across modes and widths
    for (int i = 0; i < 8; i++) begin
      logic [22:0] v;
      int n;
      string tag;
      v = VEC[i];
      tag = (v[22:21] == 2'b00) ? "R4" : (v[8] ? "R6" : "R5");
      load(v[22:21], int'(v[20:15]), int'(v[14:12]), int'(v[11:9]));
      ie_seg_stop = v[8];
      set_en();
      check({tag, " started"}, int'(en), 1);
      n = 0;
      for (int k = 0; k < 100; k++) begin
        if (!en) break;
        unit_done = 1;
        @(negedge clk);
        n++;
      end
      unit_done = 0;
      check({tag, " units"}, n, int'(v[7:1]));
      check({tag, " end flag"}, int'(end_flag), int'(v[0]));
      check({tag, " seg flag"}, int'(seg_flag), int'(!v[0]));
      check({tag, " act"}, int'(act), 0);
      clr_flags();
      ie_seg_stop = 0;
    end
    check("R10 cleared", int'({end_flag, seg_flag}), 0);

    // R2 reserved mode
    load(2'b11, 0, 2, 2);
    set_en();
    check("R2 reserved", int'(en), 0);

    // R3 zero count
    load(2'b00, 0, 0, 0);
    set_en();
    check("R3 zero main", int'(en), 0);
    load(2'b01, 0, 0, 3);
    set_en();
    check("R3 zero seg", int'(en), 0);

    // R8 strobes while idle
    load(2'b00, 4, 0, 0);
    unit_pulse();
    unit_pulse();
    check("R8 idle count", int'(main_cnt), 4);

    // R9 activity
    set_en();
    check("R9 act before unit", int'(act), 0);
    unit_pulse();
    check("R9 act after unit", int'(act), 1);
    check("R4 decrement", int'(main_cnt), 3);

    // R13 load while enabled
    load(2'b00, 9, 0, 0);
    check("R13 load ignored", int'(main_cnt), 3);

    // R12 software stop
    @(negedge clk); en_clr = 1;
    @(negedge clk); en_clr = 0;
    check("R12 en", int'(en), 0);
    check("R12 act", int'(act), 0);
    check("R12 flags", int'({end_flag, seg_flag}), 0);
    check("R12 count kept", int'(main_cnt), 3);

    // R6 / R7 stop and resume, R11 masking, R10 set-wins
    load(2'b01, 0, 3, 2);
    ie_seg_stop = 1; ie_seg_irq = 1;
    set_en();
    unit_pulse();
    unit_pulse();
    check("R6 stopped", int'(en), 0);
    check("R6 seg flag", int'(seg_flag), 1);
    check("R6 seg count", int'(seg_cnt), 2);
    check("R6 size reload", int'(size_cnt), 2);
    check("R11 irq on", int'(irq), 1);
    ie_seg_irq = 0; #1;
    check("R11 irq masked", int'(irq), 0);
    set_en();
    check("R7 resumed", int'(en), 1);
    unit_pulse();
    check("R7 size", int'(size_cnt), 1);
    check("R7 seg", int'(seg_cnt), 2);
    @(negedge clk); unit_done = 1; flag_clr = 2'b10;
    @(negedge clk); unit_done = 0; flag_clr = 2'b00;
    check("R10 set wins", int'(seg_flag), 1);
    @(negedge clk); flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00;
    check("R10 clear", int'(seg_flag), 0);

    // R5 last segment end, R11 end interrupt
    ie_seg_stop = 0;
    set_en();
    unit_pulse();
    unit_pulse();
    check("R5 end", int'(en), 0);
    check("R5 end flag", int'(end_flag), 1);
    check("R5 seg zero", int'(seg_cnt), 0);
    ie_end = 1; #1;
    check("R11 end irq", int'(irq), 1);
    ie_end = 0; #1;
    check("R11 end masked", int'(irq), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule